// File: doc/BRIEF.md
# DRAM-to-Decoder Serial Feed

This block moves audio data from DRAM to a decoder that takes its input as a serial bit stream. When the decoder asks for data and the local shifter is empty, an eight-step sequencer reads one 16-bit word from DRAM. The read address comes from a pointer slot in a counter file that the block shares with other DMA logic. The word is then parallel-loaded into a shifter. The shifter presents it to the decoder MSB first, one bit per serial clock enable.

The same sequencer runs the shared counter file through select, increment, decrement and write-back strobes. The file itself sits outside the block. It presents the selected slot's value on `cnt_val_i`. On a write strobe it stores that value plus one when increment is asserted, or minus one when decrement is asserted. During a fetch the sequencer advances the read pointer by two byte addresses and takes one off a second slot that counts words. Row and column addresses come from the pointer through an address multiplexer. RAS and CAS are driven directly.

Top module: `dram_serial_feed`

## Requirements
- R1: After reset, `cnt_sel_o` is all zero, every DRAM and counter strobe is low, `dram_addr_o` is zero, `sreq_o` is 1 and `sdata_o` is 0.
- R2: A fetch begins, with the sequencer in its first step on the next cycle, only when the sequencer is idle, `dreq_i` is high and the shifter is empty. `dreq_i` has no effect while the shifter holds bits or a fetch is running.
- R3: `cnt_sel_o` is a mask in which bit k selects counter slot k. In steps 0 to 5 only bit 2 (the pointer slot) is set. Step 0 drives nothing else. Step 1 sets `dram_addr_oe_o` and drives the row address, which is pointer bits [19:10]. `dram_addr_o` is zero whenever `dram_addr_oe_o` is low.
- R4: Step 2 asserts RAS and increment, keeps `dram_addr_oe_o` high and drives the column address, which is pointer bits [9:0]. Step 3 asserts RAS, CAS, increment and write.
- R5: Step 4 holds RAS, CAS and increment, and captures `dram_dq_i` as sampled at the end of that step.
- R6: Step 5 drops RAS and CAS, asserts increment and write, and loads the captured word into the shifter. After a whole fetch the pointer slot has advanced by two.
- R7: Steps 6 and 7 select only slot 0 with decrement asserted. Step 7 also asserts write, so the slot loses one. The sequencer then returns to idle, having taken exactly eight cycles.
- R8: CAS is asserted only while RAS is asserted and RAS was already high in the cycle before.
- R9: `sdata_o` shows bit 15 of the loaded word first. Each cycle with `bit_en_i` high advances it by one bit. `bit_en_i` has no effect while the shifter is empty.
- R10: `sreq_o` is high exactly when the shifter is empty. It falls on the cycle after step 5 and rises once the 16th bit has been shifted out.
- R11: Increment and decrement are never asserted together. Write is asserted only when exactly one slot is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq_i | input | 1 | Decoder asks for more data |
| bit_en_i | input | 1 | Serial clock enable; one bit moves per high cycle |
| dram_dq_i | input | 16 | DRAM read data |
| cnt_val_i | input | 20 | Value of the selected counter slot |
| cnt_sel_o | output | 4 | Counter slot select mask |
| cnt_inc_o | output | 1 | Counter increment |
| cnt_dec_o | output | 1 | Counter decrement |
| cnt_wr_o | output | 1 | Counter write-back |
| dram_addr_o | output | 10 | Multiplexed DRAM row or column address |
| dram_addr_oe_o | output | 1 | Address driver enable |
| dram_ras_o | output | 1 | Row strobe, active high |
| dram_cas_o | output | 1 | Column strobe, active high |
| sdata_o | output | 1 | Serial data to the decoder |
| sreq_o | output | 1 | Shifter empty; next word wanted |

## Verification
The assertions check on every cycle:
- that CAS only ever follows RAS;
- that the counter controls never conflict;
- that the sequencer cannot leave idle without both a request and an empty shifter;
- that step 7 always returns to idle;
- that a load always fills the shifter, and only after a capture;
- that the shifter's bit count stays in range.

Only the bench scenarios can show the following:
- that each step drives its exact set of strobes and the right row or column half of the pointer;
- that the pointer really ends two higher and the word count one lower through the shared file;
- that the word captured is the one present while both strobes are held;
- that the bits come out MSB first, whether the enables are spaced or back to back, and that a request raised mid-word waits for the last bit.

// File: rtl/sfeed_pkg.sv
package sfeed_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_F0,
        ST_F1,
        ST_F2,
        ST_F3,
        ST_F4,
        ST_F5,
        ST_F6,
        ST_F7
    } feed_st_e;

    // Control strobes produced by the sequencer for each step.
    typedef struct packed {
        logic sel_ptr;   // select the read-pointer slot
        logic sel_cnt;   // select the word-count slot
        logic inc;       // counter adder +1
        logic dec;       // counter adder -1
        logic wr;        // write counter adder result back
        logic use_row;   // address mux picks the row half
        logic addr_oe;   // address drivers on
        logic ras;
        logic cas;
        logic latch;     // capture DRAM data into the holding register
        logic load;      // parallel-load the shifter
    } feed_ctl_t;

    function automatic feed_ctl_t ctl_of(input feed_st_e st);
        feed_ctl_t c;
        c = '0;
        unique case (st)
            ST_F0: begin
                c.sel_ptr = 1'b1;
            end
            ST_F1: begin
                c.sel_ptr = 1'b1;
                c.use_row = 1'b1;
                c.addr_oe = 1'b1;
            end
            ST_F2: begin
                c.sel_ptr = 1'b1;
                c.ras     = 1'b1;
                c.inc     = 1'b1;
                c.addr_oe = 1'b1;
            end
            ST_F3: begin
                c.sel_ptr = 1'b1;
                c.ras     = 1'b1;
                c.cas     = 1'b1;
                c.inc     = 1'b1;
                c.wr      = 1'b1;
            end
            ST_F4: begin
                c.sel_ptr = 1'b1;
                c.ras     = 1'b1;
                c.cas     = 1'b1;
                c.inc     = 1'b1;
                c.latch   = 1'b1;
            end
            ST_F5: begin
                c.sel_ptr = 1'b1;
                c.inc     = 1'b1;
                c.wr      = 1'b1;
                c.load    = 1'b1;
            end
            ST_F6: begin
                c.sel_cnt = 1'b1;
                c.dec     = 1'b1;
            end
            ST_F7: begin
                c.sel_cnt = 1'b1;
                c.dec     = 1'b1;
                c.wr      = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfeed_seq.sv
module sfeed_seq
    import sfeed_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int PTR_SLOT  = 2,
    parameter int CNT_SLOT  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dreq_i,
    input  logic                 empty_i,
    output feed_ctl_t            ctl_o,
    output logic [NUM_SLOTS-1:0] sel_o
);

    typedef struct packed {
        feed_st_e  st;
        feed_ctl_t ctl;
    } seq_t;

    seq_t seq_q, seq_d;

    // Next step and its strobes; strobes are registered together with the step.
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: if (dreq_i && empty_i) seq_d.st = ST_F0;
            ST_F0:   seq_d.st = ST_F1;
            ST_F1:   seq_d.st = ST_F2;
            ST_F2:   seq_d.st = ST_F3;
            ST_F3:   seq_d.st = ST_F4;
            ST_F4:   seq_d.st = ST_F5;
            ST_F5:   seq_d.st = ST_F6;
            ST_F6:   seq_d.st = ST_F7;
            ST_F7:   seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
        seq_d.ctl = ctl_of(seq_d.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ctl_o = seq_q.ctl;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_sel
        assign sel_o[k] = (seq_q.ctl.sel_ptr && (k == PTR_SLOT)) ||
                          (seq_q.ctl.sel_cnt && (k == CNT_SLOT));
    end

    // R2: no departure from idle without a request and an empty shifter
    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && !(dreq_i && empty_i)) |=> (seq_q.st == ST_IDLE));

    // R7: the last step always hands back to idle
    p_end_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_F7) |=> (seq_q.st == ST_IDLE));

    // R8: CAS only under a RAS that was already up
    p_cas_after_ras_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.ctl.cas) |-> (seq_q.ctl.ras && $past(seq_q.ctl.ras)));

    // R11: adder direction never conflicts
    p_inc_dec_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_q.ctl.inc && seq_q.ctl.dec));

    // R11: a write-back always targets exactly one slot
    p_wr_one_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ctl.wr |-> ($countones(sel_o) == 1));

endmodule

// File: rtl/sfeed_addr_mux.sv
module sfeed_addr_mux #(
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 10
) (
    input  logic [CNT_W-1:0]  ptr_i,
    input  logic              use_row_i,
    input  logic              oe_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int ROW_HI = CNT_W - 1;

    logic [ADDR_W-1:0] row_addr, col_addr;

    assign row_addr = ptr_i[ROW_HI -: ADDR_W];
    assign col_addr = ptr_i[ADDR_W-1:0];

    always_comb begin
        if (!oe_i)          addr_o = '0;
        else if (use_row_i) addr_o = row_addr;
        else                addr_o = col_addr;
    end

endmodule

// File: rtl/sfeed_piso.sv
module sfeed_piso #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] dq_i,
    input  logic              latch_i,
    input  logic              load_i,
    input  logic              bit_en_i,
    output logic              sdata_o,
    output logic              empty_o
);

    localparam int CW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] sh;
        logic [CW-1:0]     left;
    } piso_t;

    piso_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (latch_i) p_d.hold = dq_i;
        if (load_i) begin
            p_d.sh   = p_q.hold;
            p_d.left = CW'(WORD_W);
        end else if (bit_en_i && (p_q.left != '0)) begin
            p_d.sh   = {p_q.sh[WORD_W-2:0], 1'b0};
            p_d.left = p_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign sdata_o = p_q.sh[WORD_W-1];
    assign empty_o = (p_q.left == '0);

    // R10: a parallel load leaves the shifter non-empty
    p_load_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !empty_o);

    // R6: the word loaded was captured on the cycle before
    p_latch_then_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> $past(latch_i));

    // R9: an empty shifter stays empty until the next load
    p_empty_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !load_i) |=> empty_o);

    // R9: bit count never exceeds a word
    p_left_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.left <= CW'(WORD_W));

endmodule

// File: rtl/dram_serial_feed.sv
module dram_serial_feed
    import sfeed_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 10,
    parameter int CNT_W     = 20,
    parameter int NUM_SLOTS = 4,
    parameter int PTR_SLOT  = 2,
    parameter int CNT_SLOT  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dreq_i,
    input  logic                 bit_en_i,
    input  logic [WORD_W-1:0]    dram_dq_i,
    input  logic [CNT_W-1:0]     cnt_val_i,
    output logic [NUM_SLOTS-1:0] cnt_sel_o,
    output logic                 cnt_inc_o,
    output logic                 cnt_dec_o,
    output logic                 cnt_wr_o,
    output logic [ADDR_W-1:0]    dram_addr_o,
    output logic                 dram_addr_oe_o,
    output logic                 dram_ras_o,
    output logic                 dram_cas_o,
    output logic                 sdata_o,
    output logic                 sreq_o
);

    feed_ctl_t ctl;
    logic      empty;

    sfeed_seq #(
        .NUM_SLOTS(NUM_SLOTS),
        .PTR_SLOT (PTR_SLOT),
        .CNT_SLOT (CNT_SLOT)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .dreq_i (dreq_i),
        .empty_i(empty),
        .ctl_o  (ctl),
        .sel_o  (cnt_sel_o)
    );

    sfeed_addr_mux #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W)
    ) u_amux (
        .ptr_i    (cnt_val_i),
        .use_row_i(ctl.use_row),
        .oe_i     (ctl.addr_oe),
        .addr_o   (dram_addr_o)
    );

    sfeed_piso #(
        .WORD_W(WORD_W)
    ) u_piso (
        .clk     (clk),
        .rst_n   (rst_n),
        .dq_i    (dram_dq_i),
        .latch_i (ctl.latch),
        .load_i  (ctl.load),
        .bit_en_i(bit_en_i),
        .sdata_o (sdata_o),
        .empty_o (empty)
    );

    assign cnt_inc_o      = ctl.inc;
    assign cnt_dec_o      = ctl.dec;
    assign cnt_wr_o       = ctl.wr;
    assign dram_addr_oe_o = ctl.addr_oe;
    assign dram_ras_o     = ctl.ras;
    assign dram_cas_o     = ctl.cas;
    assign sreq_o         = empty;

    // R10: request falls only through a load
    p_req_falls_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sreq_o) |-> $past(ctl.load));

endmodule

// File: tb/dram_serial_feed_tb_top.sv
module dram_serial_feed_tb_top;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = 20;
    localparam int NSL    = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              dreq = 1'b0;
    logic              bit_en = 1'b0;
    logic [WORD_W-1:0] dram_dq;
    logic [CNT_W-1:0]  cnt_val;
    logic [NSL-1:0]    cnt_sel;
    logic              cnt_inc, cnt_dec, cnt_wr;
    logic [ADDR_W-1:0] dram_addr;
    logic              addr_oe, ras, cas, sdata, sreq;

    dram_serial_feed dut_i (
        .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .bit_en_i(bit_en),
        .dram_dq_i(dram_dq), .cnt_val_i(cnt_val), .cnt_sel_o(cnt_sel),
        .cnt_inc_o(cnt_inc), .cnt_dec_o(cnt_dec), .cnt_wr_o(cnt_wr),
        .dram_addr_o(dram_addr), .dram_addr_oe_o(addr_oe),
        .dram_ras_o(ras), .dram_cas_o(cas), .sdata_o(sdata), .sreq_o(sreq)
    );

    // Bench model of the shared counter file and of the DRAM.
    logic [CNT_W-1:0]  slot_m [NSL];
    logic [WORD_W-1:0] mem_word = '0;

    assign dram_dq = (ras && cas) ? mem_word : ~mem_word;

    always_comb begin
        cnt_val = slot_m[2];
        for (int k = 0; k < NSL; k++) if (cnt_sel[k]) cnt_val = slot_m[k];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            slot_m[0] <= 20'd5;
            slot_m[1] <= '0;
            slot_m[2] <= 20'h3FFFE;
            slot_m[3] <= '0;
        end else if (cnt_wr) begin
            for (int k = 0; k < NSL; k++)
                if (cnt_sel[k]) slot_m[k] <= cnt_val + (cnt_inc ? 20'd1 : 20'd0) - (cnt_dec ? 20'd1 : 20'd0);
        end
    end

    typedef struct packed {
        logic [NSL-1:0]    sel;
        logic              inc, dec, wr, ras, cas, oe;
        logic [ADDR_W-1:0] addr;
    } obs_t;

    obs_t exp_q[$];
    logic exp_bits[$];
    int   checks = 0;
    int   fails  = 0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic obs_t mk(input logic [NSL-1:0] s, input logic i, input logic d, input logic w,
                                input logic r, input logic c, input logic o, input logic [ADDR_W-1:0] a);
        obs_t x;
        x = '{sel: s, inc: i, dec: d, wr: w, ras: r, cas: c, oe: o, addr: a};
        return x;
    endfunction

    // Driver side: expected strobe records for one fetch and the word's bits.
    task automatic push_word(input logic [WORD_W-1:0] w);
        logic [CNT_W-1:0] p;
        p = slot_m[2];
        exp_q.push_back(mk(4'b0100, 0, 0, 0, 0, 0, 0, '0));                 // R3 step 0
        exp_q.push_back(mk(4'b0100, 0, 0, 0, 0, 0, 1, p[19:10]));           // R3 step 1 row
        exp_q.push_back(mk(4'b0100, 1, 0, 0, 1, 0, 1, p[9:0]));             // R4 step 2 col
        exp_q.push_back(mk(4'b0100, 1, 0, 1, 1, 1, 0, '0));                 // R4 step 3
        exp_q.push_back(mk(4'b0100, 1, 0, 0, 1, 1, 0, '0));                 // R5 step 4
        exp_q.push_back(mk(4'b0100, 1, 0, 1, 0, 0, 0, '0));                 // R6 step 5
        exp_q.push_back(mk(4'b0001, 0, 1, 0, 0, 0, 0, '0));                 // R7 step 6
        exp_q.push_back(mk(4'b0001, 0, 1, 1, 0, 0, 0, '0));                 // R7 step 7
        for (int b = WORD_W - 1; b >= 0; b--) exp_bits.push_back(w[b]);
    endtask

    // Monitor side.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cnt_sel != '0) begin
                obs_t got, exp;
                got = mk(cnt_sel, cnt_inc, cnt_dec, cnt_wr, ras, cas, addr_oe, dram_addr);
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R2 unexpected fetch activity actual=%h expected=idle", got);
                end else begin
                    exp = exp_q.pop_front();
                    chk("R3/R4/R5/R6/R7/R8/R11 step strobes", 32'(got), 32'(exp));
                end
            end
            if (bit_en && !sreq) begin
                if (exp_bits.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R9 unexpected bit actual=%b expected=none", sdata);
                end else begin
                    logic e;
                    e = exp_bits.pop_front();
                    chk("R9 serial bit MSB first", 32'(sdata), 32'(e));
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic fetch(input logic [WORD_W-1:0] w);
        mem_word = w;
        push_word(w);
        tick(1);
        dreq = 1'b1;
        tick(10);
        chk("R10 request low after load", 32'(sreq), 32'd0);
        chk("R7 sequence done in eight steps", 32'(exp_q.size()), 32'd0);
        tick(4);                         // dreq still high, shifter full: R2
        dreq = 1'b0;
        chk("R2 no refetch while full", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic drain_spaced(input int nbits, input int gap);
        for (int i = 0; i < nbits; i++) begin
            bit_en = 1'b1;
            tick(1);
            bit_en = 1'b0;
            tick(gap);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R2 watchdog actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 select idle", 32'(cnt_sel), 32'd0);
        chk("R1 strobes idle", 32'({cnt_inc, cnt_dec, cnt_wr, ras, cas, addr_oe}), 32'd0);
        chk("R1 address zero", 32'(dram_addr), 32'd0);
        chk("R1 request high", 32'(sreq), 32'd1);
        chk("R1 data low", 32'(sdata), 32'd0);

        // R9: enables while empty change nothing
        drain_spaced(3, 1);
        chk("R9 empty ignores enable", 32'(sreq), 32'd1);
        tick(5);
        chk("R2 no fetch without request", 32'(exp_q.size()), 32'd0);

        // First word: pointer crosses a row boundary.
        fetch(16'hA5C3);
        chk("R6 pointer advanced by two", 32'(slot_m[2]), 32'h40000);
        chk("R7 count lowered by one", 32'(slot_m[0]), 32'd4);
        drain_spaced(15, 2);
        chk("R10 request low before last bit", 32'(sreq), 32'd0);
        drain_spaced(1, 0);
        chk("R10 request high after 16 bits", 32'(sreq), 32'd1);
        chk("R9 all bits consumed", 32'(exp_bits.size()), 32'd0);

        // Second word: back-to-back enables with extra enables after empty.
        fetch(16'h8001);
        bit_en = 1'b1;
        tick(20);
        bit_en = 1'b0;
        chk("R10 request high after burst", 32'(sreq), 32'd1);
        chk("R9 burst bits consumed", 32'(exp_bits.size()), 32'd0);

        // Third word, with a request raised mid-word for the fourth.
        fetch(16'h7FFE);
        drain_spaced(8, 1);
        mem_word = 16'h1234;
        push_word(16'h1234);
        dreq = 1'b1;
        tick(3);
        chk("R2 request waits for empty shifter", 32'(exp_q.size()), 32'd8);
        drain_spaced(8, 1);
        tick(12);
        dreq = 1'b0;
        chk("R2 fetch followed last bit", 32'(exp_q.size()), 32'd0);
        chk("R10 request low after fourth load", 32'(sreq), 32'd0);
        drain_spaced(16, 0);
        chk("R10 request high at end", 32'(sreq), 32'd1);
        chk("R6 pointer after four words", 32'(slot_m[2]), 32'h40006);
        chk("R7 count after four words", 32'(slot_m[0]), 32'd1);
        chk("R9 every bit seen", 32'(exp_bits.size()), 32'd0);
        tick(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule